// File: doc/BRIEF.md
# Half-Word Staged Register Bridge

This block connects an external host on an asynchronous bus (chip select, read strobe, write strobe, address and data) to a small bank of internal control registers. Some registers hold 32 bits and some hold 16 bits. The host is either 32 bits wide or 16 bits wide, selected by a static mode input. A 16-bit host reaches a 32-bit register through a 16-bit staging register.

To write a 32-bit register, a 16-bit host first writes the most significant half-word into the staging register. It then writes the least significant half-word to the target address. The bridge joins the two halves and updates the target in a single operation. To read a 32-bit register, the host gets the most significant half-word back on the data bus straight away. The least significant half-word is copied into the staging register, where a later read of that register collects it.

The bus strobes are brought into the clock domain through a synchronizer chain. One access is performed for each assertion of a strobe.

Top module: `hbr_bridge`

## Requirements
- R1: After reset, every register, the staging register and `rdata` read as zero.
- R2: A write to address 8 loads `wdata[15:0]` into the staging register, and `wdata[31:16]` is ignored. A read of address 8 returns the staged value in bits 15:0, with bits 31:16 zero.
- R3: With `host_wide`=0, a write to a wide register (even address 0..6) stores {staged value, `wdata[15:0]`} and leaves the staging register unchanged. A later wide write without a new staging write reuses the same upper half.
- R4: With `host_wide`=0, a read of a wide register returns its bits 31:16 in `rdata[15:0]`, with the upper bits zero. The same read copies the register's bits 15:0 into the staging register.
- R5: With `host_wide`=1, wide registers are written and read as full 32-bit words, and neither the write nor the read touches the staging register.
- R6: Narrow registers (odd address 1..7) store only `wdata[15:0]`. They read back with bits 31:16 zero in both host modes, and a write to them leaves the staging register unchanged.
- R7: Addresses 9..15 are unmapped. Writes to them change nothing, and reads of them return zero.
- R8: A strobe that is asserted while `cs_n` is high performs no access: no register changes and `rdata` holds its value.
- R9: When the read and write strobes are asserted together, only the write is performed. `rdata` holds its value and no read capture takes place.
- R10: With the default two synchronizer stages, an access takes effect on the third rising clock edge after the strobe goes low. Here, and in R9, "asserted" and "goes low" mean the strobe is sampled low on the cycle after chip select is already low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wide | input | 1 | 1 = 32-bit host, 0 = 16-bit host (static) |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| addr | input | 4 | Half-word register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, held until the next read |

## Verification
The read path and the write path can fire on the same clock edge. On a 16-bit host that edge would both write a wide register and capture its lower half into the staging register. The bench provokes this by lowering the read and write strobes together on a wide register. It first reads another wide register, so the staging register holds a known value that differs from the target's lower half. It then checks that the merged write landed in the target, that `rdata` kept the value from the earlier read, and that the staging register still holds the earlier capture.

// File: rtl/hbr_pkg.sv
package hbr_pkg;

    localparam int DATA_W   = 32;
    localparam int HALF_W   = DATA_W / 2;
    localparam int ADDR_W   = 4;
    localparam int NUM_REGS = 8;
    localparam int IDX_W    = $clog2(NUM_REGS);

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [HALF_W-1:0] half_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [IDX_W-1:0]  idx_t;

    localparam addr_t STAGE_ADDR = addr_t'(NUM_REGS);

    typedef enum logic [1:0] {
        TGT_WIDE   = 2'd0,
        TGT_NARROW = 2'd1,
        TGT_STAGE  = 2'd2,
        TGT_NONE   = 2'd3
    } tgt_e;

    typedef struct packed {
        logic  wr;
        logic  rd;
        logic  clash;
        tgt_e  tgt;
        idx_t  idx;
        half_t hi;
        half_t lo;
    } req_t;

    function automatic logic idx_is_wide(input int i);
        return (i % 2) == 0;
    endfunction

    function automatic tgt_e classify(input addr_t a);
        if (a < addr_t'(NUM_REGS))
            return a[0] ? TGT_NARROW : TGT_WIDE;
        else if (a == STAGE_ADDR)
            return TGT_STAGE;
        else
            return TGT_NONE;
    endfunction

endpackage

// File: rtl/hbr_sync.sv
module hbr_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hbr_decode.sv
module hbr_decode
    import hbr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cs_s,
    input  logic  rd_s,
    input  logic  wr_s,
    input  addr_t addr,
    input  word_t wdata,
    output req_t  req
);
    logic rd_q, wr_q;
    logic rd_evt, wr_evt;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= 1'b0;
            wr_q <= 1'b0;
        end else begin
            rd_q <= rd_s;
            wr_q <= wr_s;
        end
    end

    assign rd_evt = cs_s && rd_s && !rd_q;
    assign wr_evt = cs_s && wr_s && !wr_q;

    always_comb begin
        req.wr    = wr_evt;
        req.rd    = rd_evt && !wr_evt;
        req.clash = rd_evt && wr_evt;
        req.tgt   = classify(addr);
        req.idx   = addr[IDX_W-1:0];
        req.hi    = wdata[DATA_W-1:HALF_W];
        req.lo    = wdata[HALF_W-1:0];
    end

    p_one_op_r9: assert property (@(posedge clk) disable iff (rst)
        req.clash |-> (req.wr && !req.rd));

    p_no_cs_no_op_r8: assert property (@(posedge clk) disable iff (rst)
        !cs_s |-> !(req.wr || req.rd));
endmodule

// File: rtl/hbr_stage.sv
module hbr_stage
    import hbr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  bus_ld,
    input  half_t bus_val,
    input  logic  cap_ld,
    input  half_t cap_val,
    output half_t q
);
    always_ff @(posedge clk) begin
        if (rst)         q <= '0;
        else if (bus_ld) q <= bus_val;
        else if (cap_ld) q <= cap_val;
    end

    p_bus_load_r2: assert property (@(posedge clk) disable iff (rst)
        bus_ld |=> q == $past(bus_val));
endmodule

// File: rtl/hbr_regfile.sv
module hbr_regfile
    import hbr_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            we,
    input  idx_t                            widx,
    input  word_t                           wval,
    output logic [NUM_REGS-1:0][DATA_W-1:0] regs_q
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (idx_is_wide(i)) begin : g_wide
            always_ff @(posedge clk) begin
                if (rst)                             regs_q[i] <= '0;
                else if (we && widx == idx_t'(i))    regs_q[i] <= wval;
            end
        end else begin : g_narrow
            always_ff @(posedge clk) begin
                if (rst)                             regs_q[i] <= '0;
                else if (we && widx == idx_t'(i))    regs_q[i] <= {{HALF_W{1'b0}}, wval[HALF_W-1:0]};
            end

            p_narrow_keep_r6: assert property (@(posedge clk) disable iff (rst)
                (we && widx == idx_t'(i)) |=>
                    (regs_q[i][HALF_W-1:0] == $past(wval[HALF_W-1:0]) &&
                     regs_q[i][DATA_W-1:HALF_W] == '0));
        end
    end

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(regs_q));
endmodule

// File: rtl/hbr_bridge.sv
module hbr_bridge
    import hbr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_wide,
    input  logic        cs_n,
    input  logic        rd_n,
    input  logic        wr_n,
    input  logic [3:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata
);
    logic [2:0] strb_s;
    req_t       req;
    half_t      stage_q;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
    word_t      sel;
    word_t      wval;
    logic       rf_we;
    logic       stg_bus_ld;
    logic       stg_cap_ld;

    hbr_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   ({~cs_n, ~rd_n, ~wr_n}),
        .q   (strb_s)
    );

    hbr_decode i_decode (
        .clk   (clk),
        .rst   (rst),
        .cs_s  (strb_s[2]),
        .rd_s  (strb_s[1]),
        .wr_s  (strb_s[0]),
        .addr  (addr),
        .wdata (wdata),
        .req   (req)
    );

    assign sel = regs_q[req.idx];

    always_comb begin
        unique case (req.tgt)
            TGT_WIDE:   wval = host_wide ? {req.hi, req.lo} : {stage_q, req.lo};
            TGT_NARROW: wval = {{HALF_W{1'b0}}, req.lo};
            default:    wval = '0;
        endcase
    end

    assign rf_we      = req.wr && (req.tgt == TGT_WIDE || req.tgt == TGT_NARROW);
    assign stg_bus_ld = req.wr && (req.tgt == TGT_STAGE);
    assign stg_cap_ld = req.rd && (req.tgt == TGT_WIDE) && !host_wide;

    hbr_regfile i_regfile (
        .clk    (clk),
        .rst    (rst),
        .we     (rf_we),
        .widx   (req.idx),
        .wval   (wval),
        .regs_q (regs_q)
    );

    hbr_stage i_stage (
        .clk     (clk),
        .rst     (rst),
        .bus_ld  (stg_bus_ld),
        .bus_val (req.lo),
        .cap_ld  (stg_cap_ld),
        .cap_val (sel[HALF_W-1:0]),
        .q       (stage_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (req.rd) begin
            unique case (req.tgt)
                TGT_WIDE:   rdata <= host_wide ? sel : {{HALF_W{1'b0}}, sel[DATA_W-1:HALF_W]};
                TGT_NARROW: rdata <= {{HALF_W{1'b0}}, sel[HALF_W-1:0]};
                TGT_STAGE:  rdata <= {{HALF_W{1'b0}}, stage_q};
                default:    rdata <= '0;
            endcase
        end
    end

    p_merge_r3: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.tgt == TGT_WIDE && !host_wide) |=>
            (regs_q[$past(req.idx)] == {$past(stage_q), $past(req.lo)}));

    p_stage_kept_r3: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.tgt == TGT_WIDE) |=> $stable(stage_q));

    p_capture_r4: assert property (@(posedge clk) disable iff (rst)
        (req.rd && req.tgt == TGT_WIDE && !host_wide) |=>
            (stage_q == $past(sel[HALF_W-1:0]) && rdata[DATA_W-1:HALF_W] == '0));

    p_wide_full_r5: assert property (@(posedge clk) disable iff (rst)
        (req.rd && req.tgt == TGT_WIDE && host_wide) |=>
            (rdata == $past(sel) && $stable(stage_q)));

    p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (req.rd && req.tgt == TGT_NONE) |=> rdata == '0);

    p_clash_hold_r9: assert property (@(posedge clk) disable iff (rst)
        req.clash |=> $stable(rdata));
endmodule

// File: tb/test_hbr_bridge.sv
`timescale 1ns/1ps
module test_hbr_bridge;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wide = 1'b0;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [31:0] m_reg [8];
    logic [15:0] m_stage;

    always #10 clk = ~clk;

    hbr_bridge i_hbr_bridge (
        .clk(clk), .rst(rst), .host_wide(host_wide), .cs_n(cs_n),
        .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic strobe(input logic do_rd, input logic do_wr, input logic sel,
                          input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; cs_n = ~sel;
        @(negedge clk);
        rd_n = ~do_rd; wr_n = ~do_wr;
        repeat (5) @(negedge clk);
        rd_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [31:0] exp_rd(input int a);
        if (a < 8) begin
            if (a % 2 == 0) return host_wide ? m_reg[a] : {16'h0, m_reg[a][31:16]};
            else            return {16'h0, m_reg[a][15:0]};
        end else if (a == 8) return {16'h0, m_stage};
        return 32'h0;
    endfunction

    function automatic void model_wr(input int a, input logic [31:0] d);
        if (a == 8) m_stage = d[15:0];
        else if (a < 8) begin
            if (a % 2 == 0) m_reg[a] = host_wide ? d : {m_stage, d[15:0]};
            else            m_reg[a] = {16'h0, d[15:0]};
        end
    endfunction

    function automatic void model_rd(input int a);
        if (a < 8 && a % 2 == 0 && !host_wide) m_stage = m_reg[a][15:0];
    endfunction

    task automatic bwrite(input int a, input logic [31:0] d);
        strobe(1'b0, 1'b1, 1'b1, 4'(a), d);
        model_wr(a, d);
    endtask

    task automatic bread(input int a, input string tag);
        strobe(1'b1, 1'b0, 1'b1, 4'(a), 32'h0);
        check(rdata, exp_rd(a), tag);
        model_rd(a);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) m_reg[i] = '0;
        m_stage = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(rdata, 32'h0, "R1 rdata after reset");
        for (int a = 0; a < 16; a++) bread(a, "R1 reset contents");

        // 16-bit host: staging and merged writes
        bwrite(8, 32'hDEAD_A5A5);
        bread(8, "R2 stage readback");
        for (int i = 0; i < 8; i += 2) begin
            bwrite(8, 32'hFFFF_1000 + 32'(i) * 32'h0111);
            bwrite(i, 32'hFFFF_2000 + 32'(i) * 32'h0101);
        end
        bwrite(0, 32'h0000_4444);
        bread(8, "R3 stage kept after wide writes");
        for (int j = 1; j < 8; j += 2) begin
            bwrite(j, 32'hBEEF_3000 + 32'(j));
            bread(8, "R6 stage kept after narrow write");
        end
        for (int i = 0; i < 8; i++) begin
            bread(i, (i % 2 == 0) ? "R4 wide upper half" : "R6 narrow readback");
            if (i % 2 == 0) bread(8, "R4 captured lower half");
        end

        // unmapped addresses
        for (int a = 9; a < 16; a++) bwrite(a, 32'hFFFF_FFFF);
        for (int a = 0; a < 16; a++) bread(a, "R7 unmapped sweep");

        // strobes without chip select
        bread(3, "R8 setup read");
        strobe(1'b0, 1'b1, 1'b0, 4'd1, 32'h0000_7777);
        strobe(1'b1, 1'b0, 1'b0, 4'd0, 32'h0);
        check(rdata, exp_rd(3), "R8 rdata held without cs");
        bread(1, "R8 register untouched");

        // 32-bit host
        host_wide = 1'b1;
        for (int i = 0; i < 8; i++) bwrite(i, 32'hC0DE_0000 + 32'(i) * 32'h0101_0101);
        for (int i = 0; i < 8; i++) bread(i, "R5 full word readback");
        bread(8, "R5 stage untouched in wide mode");

        // collision of read and write strobes
        host_wide = 1'b0;
        bread(4, "R9 setup read");
        strobe(1'b1, 1'b1, 1'b1, 4'd2, 32'h1234_5678);
        check(rdata, {16'h0, m_reg[4][31:16]}, "R9 rdata held on clash");
        model_wr(2, 32'h1234_5678);
        bread(8, "R9 no capture on clash");
        bread(2, "R9 write performed on clash");

        // latency
        @(negedge clk);
        addr = 4'd6; cs_n = 1'b0;
        @(negedge clk);
        rd_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(rdata, {16'h0, m_reg[2][31:16]}, "R10 old value after two edges");
        @(negedge clk);
        check(rdata, exp_rd(6), "R10 new value after three edges");
        model_rd(6);
        repeat (3) @(negedge clk);
        rd_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        bread(8, "R10 capture after timed read");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule